// File: doc/BRIEF.md
# Predicated In-Place Tree Reduction Unit

This unit holds a bank of element registers and folds the active ones into a single value with a binary tree of combines. A per-element predicate marks which lanes take part. The combine is either modular addition or modular multiplication. Each round pairs lanes at a distance that doubles from one round to the next. Each combine result lands back in one of the two lanes it read, so no partial value is ever copied or relocated. When the run ends, the total sits in the lowest-numbered active lane. Inactive lanes keep the value they were loaded with. Inactive lanes are never replaced by zero or one, so a product is never forced to zero by an idle lane.

Software loads all lanes in parallel while the unit is idle. It then pulses `start` together with a predicate and an operation code. The unit raises `busy` for one cycle per round and pulses `done` once. All lanes can then be read back in parallel on `elem_out`.

Top module: `tree_reduce_unit`

## Requirements
- R1: Reset clears every lane to 0 and deasserts `busy` and `done`. When the unit is idle and `load_en` is high, all lanes take `load_data` on the next edge, with lane i in bits [i*W +: W].
- R2: A `start` seen while idle captures `pred` and `op_sel`. `busy` then stays high for exactly log2(N) cycles (3 for N=8). `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R3: While `busy` is high, `start`, `load_en`, `load_data`, `pred` and `op_sel` have no effect on the run or its result.
- R4: A lane whose captured predicate bit is 0 is never written. It keeps its loaded value through the run.
- R5: At the end of a run, the lowest-indexed active lane holds the fold of all active lanes. Operation code 0 selects addition modulo 2^W and code 1 selects multiplication modulo 2^W. Inactive lanes do not contribute any value, not even zero or one.
- R6: Round r uses stride s=2^r. In every aligned block of 2s lanes, the lowest active lane of the lower half becomes lower op upper, where upper is the lowest active lane of the upper half. This happens only when both halves hold an active lane. No other lane changes. Example: predicate 8'hF0 over values 1,2,3,4,9,5,6,8 ends as 1,2,3,4,28,5,14,8.
- R7: A run with zero active lanes or exactly one active lane still lasts log2(N) cycles, and it writes no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Parallel load strobe, honoured only when idle |
| load_data | input | N*W | Lane values to load, lane i at [i*W +: W] |
| start | input | 1 | Begin a run, honoured only when idle |
| pred | input | N | Per-lane predicate, bit i enables lane i |
| op_sel | input | 1 | 0: add modulo 2^W, 1: multiply modulo 2^W |
| busy | output | 1 | High during the reduction rounds |
| done | output | 1 | One-cycle pulse after the last round |
| elem_out | output | N*W | Current contents of all lanes |

## Verification
The assertions assume a synchronous reset held for at least one edge. They also assume that the predicate and operation seen by the datapath are the copies captured at `start`, not the live inputs. The stimulus deliberately toggles `start`, `load_en`, `pred` and `op_sel` while `busy` is high. It also loads and starts only from idle cycles, so every run begins from a known lane state. Random predicates and values come from a fixed-seed generator. They are mixed with directed cases: the documented 8'hF0 pattern, empty and single-lane masks, a full mask, and products with zero-valued idle lanes.

// File: rtl/tree_reduce_pkg.sv
package tree_reduce_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } tr_op_e;

endpackage

// File: rtl/tree_round_plan.sv
// Decides, for one round, which lanes are combine destinations and where
// each destination fetches its second operand from.
module tree_round_plan #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int RW = 2
) (
    input  logic [N-1:0]          pred,
    input  logic [RW-1:0]         round,
    output logic [N-1:0]          wr_en,
    output logic [N-1:0][IW-1:0]  src_idx
);

    always_comb begin
        wr_en   = '0;
        src_idx = '0;
        for (int i = 0; i < N; i++) begin
            int  st;
            int  blk;
            int  base;
            int  lo_idx;
            int  hi_idx;
            logic lo_hit;
            logic hi_hit;
            st     = 1 << round;
            blk    = st * 2;
            base   = (i / blk) * blk;
            lo_hit = 1'b0;
            hi_hit = 1'b0;
            lo_idx = 0;
            hi_idx = 0;
            // scan downward so the lowest active index is the last one kept
            for (int j = N - 1; j >= 0; j--) begin
                if (pred[j] && (j >= base) && (j < base + st)) begin
                    lo_hit = 1'b1;
                    lo_idx = j;
                end
                if (pred[j] && (j >= base + st) && (j < base + blk)) begin
                    hi_hit = 1'b1;
                    hi_idx = j;
                end
            end
            wr_en[i]   = lo_hit && hi_hit && (lo_idx == i);
            src_idx[i] = IW'(hi_idx);
        end
    end

endmodule

// File: rtl/tree_combine_alu.sv
// Single lane combiner: modular add or modular multiply, low W bits kept.
module tree_combine_alu
    import tree_reduce_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  tr_op_e       op,
    output logic [W-1:0] y
);

    logic [W-1:0] sum;
    logic [W-1:0] prod;

    assign sum  = a + b;
    assign prod = a * b;

    always_comb begin
        unique case (op)
            OP_ADD:  y = sum;
            OP_MUL:  y = prod;
            default: y = sum;
        endcase
    end

endmodule

// File: rtl/tree_reduce_unit.sv
module tree_reduce_unit
    import tree_reduce_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [N*W-1:0] load_data,
    input  logic           start,
    input  logic [N-1:0]   pred,
    input  logic           op_sel,
    output logic           busy,
    output logic           done,
    output logic [N*W-1:0] elem_out
);

    localparam int IW     = (N > 1) ? $clog2(N) : 1;
    localparam int ROUNDS = (N > 1) ? $clog2(N) : 1;
    localparam int RW     = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    typedef struct packed {
        logic [N-1:0][W-1:0] elems;
        logic [N-1:0]        pred;
        tr_op_e              op;
        logic                busy;
        logic [RW-1:0]       round;
        logic                done;
    } tr_state_t;

    tr_state_t state_d;
    tr_state_t state_q;

    logic [N-1:0]         plan_wr;
    logic [N-1:0][IW-1:0] plan_src;
    logic [N-1:0][W-1:0]  alu_y;

    tree_round_plan #(
        .N  (N),
        .IW (IW),
        .RW (RW)
    ) u_plan (
        .pred    (state_q.pred),
        .round   (state_q.round),
        .wr_en   (plan_wr),
        .src_idx (plan_src)
    );

    for (genvar g = 0; g < N; g++) begin : g_lane
        tree_combine_alu #(
            .W (W)
        ) u_alu (
            .a  (state_q.elems[g]),
            .b  (state_q.elems[plan_src[g]]),
            .op (state_q.op),
            .y  (alu_y[g])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (load_en) begin
                state_d.elems = load_data;
            end
            if (start) begin
                state_d.busy  = 1'b1;
                state_d.round = '0;
                state_d.pred  = pred;
                state_d.op    = tr_op_e'(op_sel);
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (plan_wr[i]) begin
                    state_d.elems[i] = alu_y[i];
                end
            end
            if (state_q.round == RW'(ROUNDS - 1)) begin
                state_d.busy  = 1'b0;
                state_d.done  = 1'b1;
                state_d.round = '0;
            end else begin
                state_d.round = state_q.round + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    logic [N-1:0] pred_run;
    logic         op_run;

    assign pred_run = state_q.pred;
    assign op_run   = state_q.op;
    assign busy     = state_q.busy;
    assign done     = state_q.done;
    assign elem_out = state_q.elems;

endmodule

// File: rtl/tree_reduce_chk.sv
module tree_reduce_chk #(
    parameter int N = 8,
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic [N-1:0]   pred_run,
    input logic           op_run,
    input logic [N*W-1:0] elem_out
);

    localparam int ROUNDS = (N > 1) ? $clog2(N) : 1;
    localparam int CW     = $clog2(ROUNDS + 2) + 1;

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R2
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CW'(ROUNDS)));

    // R2
    busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(busy_cnt) == CW'(ROUNDS - 1)));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pred_run) && $stable(op_run)));

    // R7
    sparse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ($countones(pred_run) <= 1)) |=> $stable(elem_out));

    for (genvar g = 0; g < N; g++) begin : g_mask
        // R4
        masked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !pred_run[g]) |=> $stable(elem_out[g*W +: W]));
    end

endmodule

bind tree_reduce_unit tree_reduce_chk #(
    .N (N),
    .W (W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .pred_run (pred_run),
    .op_run   (op_run),
    .elem_out (elem_out)
);

// File: tb/tree_reduce_unit_tb.sv
module tree_reduce_unit_tb;

    localparam int N = 8;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           load_en;
    logic [N*W-1:0] load_data;
    logic           start;
    logic [N-1:0]   pred;
    logic           op_sel;
    logic           busy;
    logic           done;
    logic [N*W-1:0] elem_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tree_reduce_unit #(.N(N), .W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_data (load_data),
        .start     (start),
        .pred      (pred),
        .op_sel    (op_sel),
        .busy      (busy),
        .done      (done),
        .elem_out  (elem_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] comb(input logic [W-1:0] a, input logic [W-1:0] b, input logic op);
        logic [W-1:0] r;
        r = op ? W'(a * b) : W'(a + b);
        return r;
    endfunction

    // reference built from the round rules of R6
    function automatic logic [N*W-1:0] model(input logic [N*W-1:0] v, input logic [N-1:0] p, input logic op);
        logic [N*W-1:0] e;
        e = v;
        for (int st = 1; st < N; st = st * 2) begin
            for (int base = 0; base < N; base += 2 * st) begin
                int lo;
                int hi;
                lo = -1;
                hi = -1;
                for (int k = base + st - 1; k >= base; k--) if (p[k]) lo = k;
                for (int k = base + 2 * st - 1; k >= base + st; k--) if (p[k]) hi = k;
                if (lo >= 0 && hi >= 0)
                    e[lo*W +: W] = comb(e[lo*W +: W], e[hi*W +: W], op);
            end
        end
        return e;
    endfunction

    task automatic load(input logic [N*W-1:0] v);
        @(negedge clk);
        load_en   = 1'b1;
        load_data = v;
        @(negedge clk);
        load_en   = 1'b0;
        for (int i = 0; i < N; i++) chk("R1 load", elem_out[i*W +: W], v[i*W +: W]);
    endtask

    task automatic run(input logic [N*W-1:0] v, input logic [N-1:0] p, input logic op, input bit meddle);
        logic [N*W-1:0] exp;
        int first;
        exp = model(v, p, op);
        first = -1;
        for (int k = N - 1; k >= 0; k--) if (p[k]) first = k;
        load(v);
        pred   = p;
        op_sel = op;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk("R2 busy", W'(busy), W'(1));
            chk("R2 done low", W'(done), W'(0));
            if (meddle) begin
                start     = 1'b1;
                load_en   = 1'b1;
                load_data = ~v;
                pred      = ~p;
                op_sel    = ~op;
            end
            @(negedge clk);
        end
        start = 1'b0; load_en = 1'b0;
        chk("R2 busy end", W'(busy), W'(0));
        chk("R2 done", W'(done), W'(1));
        @(negedge clk);
        chk("R2 done one cycle", W'(done), W'(0));
        chk("R3 no restart", W'(busy), W'(0));
        for (int i = 0; i < N; i++) begin
            if (!p[i])
                chk(meddle ? "R3 R4 masked" : "R4 masked", elem_out[i*W +: W], v[i*W +: W]);
            else if (i == first)
                chk(meddle ? "R3 R5 result" : "R5 result", elem_out[i*W +: W], exp[i*W +: W]);
            else
                chk("R6 partial", elem_out[i*W +: W], exp[i*W +: W]);
        end
        if ($countones(p) <= 1)
            for (int i = 0; i < N; i++) chk("R7 no write", elem_out[i*W +: W], v[i*W +: W]);
    endtask

    function automatic logic [N*W-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
        logic [N*W-1:0] r;
        r = {W'(a7), W'(a6), W'(a5), W'(a4), W'(a3), W'(a2), W'(a1), W'(a0)};
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N*W-1:0] v;
        void'($urandom(32'd17));
        rst_n = 1'b0; load_en = 1'b0; load_data = '0; start = 1'b0; pred = '0; op_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", W'(busy), W'(0));
        chk("R1 reset done", W'(done), W'(0));
        for (int i = 0; i < N; i++) chk("R1 reset lane", elem_out[i*W +: W], '0);

        // R6 documented pattern: expect 1,2,3,4,28,5,14,8
        v = pack8(1, 2, 3, 4, 9, 5, 6, 8);
        run(v, 8'hF0, 1'b0, 1'b0);
        chk("R6 lane4", elem_out[4*W +: W], W'(28));
        chk("R6 lane6", elem_out[6*W +: W], W'(14));
        // R7 empty and single masks
        run(v, 8'h00, 1'b0, 1'b0);
        run(v, 8'h20, 1'b1, 1'b0);
        // R5 multiply with zero-valued idle lanes
        run(pack8(0, 3, 0, 5, 0, 7, 2, 0), 8'b0110_1010, 1'b1, 1'b0);
        chk("R5 product", elem_out[1*W +: W], W'(210));
        // R5 full mask add with wrap
        run(pack8(16'hFFFF, 1, 2, 3, 4, 5, 6, 7), 8'hFF, 1'b0, 1'b0);
        chk("R5 wrap sum", elem_out[0 +: W], W'(27));
        // R3 interference during the run
        run(v, 8'b1011_0110, 1'b1, 1'b1);

        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
            run(v, N'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule